// File: doc/BRIEF.md
# Watchdog Refresh Sequence Checker

This block guards the 16-bit refresh register of a watchdog. Software refreshes the watchdog by writing a fixed pair of values in order: first `0xA602`, then `0xB480`. The register accepts full 16-bit writes and single byte-lane writes. A refresh is complete only when the first value has been seen and the second value then arrives in time. The block raises a one-cycle `refresh_done` pulse when that happens.

A write that leaves an illegal value in the register starts an exception. The legality check looks at each byte on its own. The high byte may only hold `0xA6` or `0xB4`, and the low byte may only hold `0x02` or `0x80`. This lets software build a correct value from two byte writes without a false exception. An exception either pulses `reset_req` at once, or pulses `irq` first and `reset_req` a fixed number of cycles later. The watchdog timeout counter and the reset generator that acts on `reset_req` are outside this block.

Top module: `wdog_refresh_checker`

## Requirements
- R1: During and after synchronous reset, `refresh_done`, `irq` and `reset_req` are low. The register holds `0xB480` and the tracker is idle, so writing `0xB480` first does not complete a refresh.
- R2: A write that makes the register equal `0xA602`, followed by a write that makes it equal `0xB480`, pulses `refresh_done` high for exactly one cycle. The pulse appears in the cycle right after the clock edge that accepts the second write.
- R3: Byte-lane writes are merged into the register before any check. Writing `0xA6` to the high lane and then `0x02` to the low lane matches the first value on the second write, with no exception on the first write.
- R4: If the merged register's high byte (bits 15:8) is anything other than `0xA6` or `0xB4`, an exception is raised.
- R5: If the merged register's low byte (bits 7:0) is anything other than `0x02` or `0x80`, an exception is raised.
- R6: A merged value made only of legal bytes that equals neither sequence value (for example `0xB402` or `0xA680`) raises no exception and matches nothing. The tracker state is unchanged.
- R7: The second value completes a refresh only if its write is accepted at most `WINDOW` (default 20) clock edges after the edge that accepted the first value. If the gap is `WINDOW+1` or more, the tracker drops back to idle and no refresh occurs.
- R8: Matching `0xB480` while the tracker is idle gives no refresh and no exception.
- R9: With `irq_before_reset` low when the illegal write is accepted, `reset_req` pulses for one cycle in the cycle after that edge, and `irq` stays low.
- R10: With `irq_before_reset` high, `irq` pulses for one cycle in the cycle after the illegal write. Then `reset_req` pulses for one cycle `IRQ_LEAD` (default 4) cycles after the `irq` pulse. Further exceptions are ignored while that reset is pending.
- R11: An exception returns the tracker to idle. A `0xB480` write that follows does not complete a refresh.
- R12: Byte enable bit 1 selects lane 15:8 and bit 0 selects lane 7:0. Lanes that are not enabled keep their old value. A write with both enables low has no effect and is not checked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the refresh register |
| wr_be | input | 2 | Byte-lane enables: bit 1 = high byte, bit 0 = low byte |
| wr_data | input | 16 | Write data |
| irq_before_reset | input | 1 | Selects the exception response: 1 = interrupt then reset, 0 = reset only |
| refresh_done | output | 1 | One-cycle pulse when a refresh sequence completes |
| irq | output | 1 | One-cycle interrupt pulse that comes before a delayed reset |
| reset_req | output | 1 | One-cycle reset request pulse |

## Verification
The tracker state and the stored register are both hidden, but each shows up at the ports within one write. A corrupted register byte turns the next single-lane write into a spurious or missing exception, visible on `irq` or `reset_req` in the next cycle. A tracker stuck armed, or a window counter that is off by one, shows up when a `0xB480` write lands exactly `WINDOW` or `WINDOW+1` edges after `0xA602`. A wrong pending count in the responder moves the delayed `reset_req` off its cycle. The bench runs a reference model in step with the design and compares all three outputs every cycle, so any divergence is reported in the cycle it first appears.

// File: rtl/wdr_pkg.sv
package wdr_pkg;

    localparam int DATA_W  = 16;
    localparam int LANE_W  = 8;
    localparam int LANES   = DATA_W / LANE_W;

    localparam logic [DATA_W-1:0] SEQ_FIRST  = 16'hA602;
    localparam logic [DATA_W-1:0] SEQ_SECOND = 16'hB480;
    localparam logic [DATA_W-1:0] REG_INIT   = SEQ_SECOND;

    typedef enum logic {
        TRK_IDLE  = 1'b0,
        TRK_ARMED = 1'b1
    } trk_state_e;

    typedef struct packed {
        logic act;         // an accepted write with at least one lane enabled
        logic legal;       // every byte of the merged value is allowed
        logic hit_first;   // merged value equals the first sequence value
        logic hit_second;  // merged value equals the second sequence value
    } wr_eval_t;

    function automatic logic [LANE_W-1:0] merge_lane(
        input logic [LANE_W-1:0] old_b,
        input logic [LANE_W-1:0] new_b,
        input logic              en
    );
        return en ? new_b : old_b;
    endfunction

    function automatic logic lane_allowed(
        input logic [LANE_W-1:0] b,
        input int unsigned       lane
    );
        return (b == SEQ_FIRST[lane*LANE_W +: LANE_W]) ||
               (b == SEQ_SECOND[lane*LANE_W +: LANE_W]);
    endfunction

endpackage

// File: rtl/wdr_lane_reg.sv
module wdr_lane_reg
    import wdr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [LANES-1:0]  wr_be,
    input  logic [DATA_W-1:0] wr_data,
    output wr_eval_t          eval
);
    logic [DATA_W-1:0] cur_q;
    logic [DATA_W-1:0] merged;
    logic [LANES-1:0]  lane_ok;
    logic              act;

    assign act = wr_en && (wr_be != '0);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged[g*LANE_W +: LANE_W] =
            merge_lane(cur_q[g*LANE_W +: LANE_W], wr_data[g*LANE_W +: LANE_W], wr_be[g]);
        assign lane_ok[g] = lane_allowed(merged[g*LANE_W +: LANE_W], g);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= REG_INIT;
        end else if (act) begin
            cur_q <= merged;
        end
    end

    always_comb begin
        eval.act        = act;
        eval.legal      = &lane_ok;
        eval.hit_first  = act && (merged == SEQ_FIRST);
        eval.hit_second = act && (merged == SEQ_SECOND);
    end

endmodule

// File: rtl/wdr_seq_tracker.sv
module wdr_seq_tracker
    import wdr_pkg::*;
#(
    parameter int WINDOW = 20,
    localparam int CNT_W = $clog2(WINDOW + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  wr_eval_t         eval,
    output logic             done,
    output trk_state_e       state,
    output logic [CNT_W-1:0] win_cnt
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW - 1);

    logic exc;
    assign exc = eval.act && !eval.legal;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= TRK_IDLE;
            win_cnt <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (exc) begin
                state   <= TRK_IDLE;
                win_cnt <= '0;
            end else if (eval.hit_first) begin
                state   <= TRK_ARMED;
                win_cnt <= '0;
            end else if (state == TRK_ARMED) begin
                if (eval.hit_second) begin
                    done    <= 1'b1;
                    state   <= TRK_IDLE;
                    win_cnt <= '0;
                end else if (win_cnt == LAST) begin
                    state   <= TRK_IDLE;
                    win_cnt <= '0;
                end else begin
                    win_cnt <= win_cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/wdr_exc_resp.sv
module wdr_exc_resp #(
    parameter int IRQ_LEAD = 4,
    localparam int PC_W = $clog2(IRQ_LEAD + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic exc,
    input  logic irq_mode,
    output logic irq,
    output logic reset_req,
    output logic pending
);
    localparam logic [PC_W-1:0] LEAD_V = PC_W'(IRQ_LEAD);

    logic [PC_W-1:0] pc;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq       <= 1'b0;
            reset_req <= 1'b0;
            pending   <= 1'b0;
            pc        <= '0;
        end else begin
            irq       <= 1'b0;
            reset_req <= 1'b0;
            if (pending) begin
                if (pc == LEAD_V) begin
                    reset_req <= 1'b1;
                    pending   <= 1'b0;
                    pc        <= '0;
                end else begin
                    pc <= pc + 1'b1;
                end
            end else if (exc) begin
                if (irq_mode) begin
                    irq     <= 1'b1;
                    pending <= 1'b1;
                    pc      <= PC_W'(1);
                end else begin
                    reset_req <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/wdog_refresh_checker.sv
module wdog_refresh_checker
    import wdr_pkg::*;
#(
    parameter int WINDOW   = 20,
    parameter int IRQ_LEAD = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  wr_be,
    input  logic [15:0] wr_data,
    input  logic        irq_before_reset,
    output logic        refresh_done,
    output logic        irq,
    output logic        reset_req
);
    localparam int CNT_W = $clog2(WINDOW + 1);

    wr_eval_t         eval;
    trk_state_e       trk_state;
    logic [CNT_W-1:0] win_cnt;
    logic             exc_pend;

    wdr_lane_reg reg_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_be   (wr_be),
        .wr_data (wr_data),
        .eval    (eval)
    );

    wdr_seq_tracker #(.WINDOW(WINDOW)) trk_i (
        .clk     (clk),
        .rst     (rst),
        .eval    (eval),
        .done    (refresh_done),
        .state   (trk_state),
        .win_cnt (win_cnt)
    );

    wdr_exc_resp #(.IRQ_LEAD(IRQ_LEAD)) resp_i (
        .clk       (clk),
        .rst       (rst),
        .exc       (eval.act && !eval.legal),
        .irq_mode  (irq_before_reset),
        .irq       (irq),
        .reset_req (reset_req),
        .pending   (exc_pend)
    );

endmodule

// File: rtl/wdr_checker.sv
module wdr_checker #(
    parameter int WINDOW = 20,
    parameter int CNT_W  = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [1:0]       wr_be,
    input logic [15:0]      wr_data,
    input logic             irq_before_reset,
    input logic             refresh_done,
    input logic             irq,
    input logic             reset_req,
    input logic             exc_pend,
    input logic [CNT_W-1:0] win_cnt
);
    logic hi_bad, lo_bad;
    assign hi_bad = (wr_data[15:8] != 8'hA6) && (wr_data[15:8] != 8'hB4);
    assign lo_bad = (wr_data[7:0]  != 8'h02) && (wr_data[7:0]  != 8'h80);

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        refresh_done |=> !refresh_done); // R2
    AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        refresh_done |-> $past(wr_en)); // R8
    AST_HI_BAD_RESET: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_be[1] && hi_bad && !irq_before_reset && !exc_pend) |=> reset_req); // R4
    AST_LO_BAD_IRQ: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_be[0] && lo_bad && irq_before_reset && !exc_pend) |=> irq); // R5
    AST_IRQ_ALONE: assert property (@(posedge clk) disable iff (rst)
        irq |-> !reset_req); // R10
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq); // R10
    AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (rst)
        win_cnt < CNT_W'(WINDOW)); // R7
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!refresh_done && !irq && !reset_req)); // R1

endmodule

bind wdog_refresh_checker wdr_checker #(.WINDOW(WINDOW), .CNT_W(CNT_W)) chk_i (
    .clk              (clk),
    .rst              (rst),
    .wr_en            (wr_en),
    .wr_be            (wr_be),
    .wr_data          (wr_data),
    .irq_before_reset (irq_before_reset),
    .refresh_done     (refresh_done),
    .irq              (irq),
    .reset_req        (reset_req),
    .exc_pend         (exc_pend),
    .win_cnt          (win_cnt)
);

// File: tb/wdog_refresh_checker_tb.sv
module wdog_refresh_checker_tb_top;
    localparam int WIN  = 20;
    localparam int LEAD = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_be = 2'b00;
    logic [15:0] wr_data = 16'h0000;
    logic        irq_before_reset = 1'b0;
    logic        refresh_done, irq, reset_req;

    always #4 clk = ~clk;

    wdog_refresh_checker #(.WINDOW(WIN), .IRQ_LEAD(LEAD)) dut_i (
        .clk (clk), .rst (rst), .wr_en (wr_en), .wr_be (wr_be), .wr_data (wr_data),
        .irq_before_reset (irq_before_reset),
        .refresh_done (refresh_done), .irq (irq), .reset_req (reset_req)
    );

    int    n_checks = 0;
    int    n_errors = 0;
    string cur_tag  = "R1";
    bit    finished = 0;

    // reference state
    logic [15:0] m_reg;
    bit          m_armed, m_pend;
    int          m_cnt, m_pc;
    bit          e_done, e_irq, e_rst;

    function automatic bit lane_ok(input logic [7:0] b, input int lane);
        if (lane == 1) return (b == 8'hA6) || (b == 8'hB4);
        return (b == 8'h02) || (b == 8'h80);
    endfunction

    task automatic model_reset();
        m_reg = 16'hB480; m_armed = 0; m_pend = 0; m_cnt = 0; m_pc = 0;
        e_done = 0; e_irq = 0; e_rst = 0;
    endtask

    task automatic model_edge();
        bit act, exc, h1, h2;
        logic [15:0] nv;
        act = wr_en && (wr_be != 2'b00);
        nv  = m_reg;
        if (wr_be[1]) nv[15:8] = wr_data[15:8];
        if (wr_be[0]) nv[7:0]  = wr_data[7:0];
        exc = 0; h1 = 0; h2 = 0;
        if (act) begin
            m_reg = nv;
            exc = !(lane_ok(nv[15:8], 1) && lane_ok(nv[7:0], 0));
            h1  = (nv == 16'hA602);
            h2  = (nv == 16'hB480);
        end
        e_done = 0;
        if (exc) begin
            m_armed = 0; m_cnt = 0;
        end else if (h1) begin
            m_armed = 1; m_cnt = 0;
        end else if (m_armed) begin
            if (h2) begin e_done = 1; m_armed = 0; m_cnt = 0; end
            else if (m_cnt == WIN - 1) begin m_armed = 0; m_cnt = 0; end
            else m_cnt++;
        end
        e_irq = 0; e_rst = 0;
        if (m_pend) begin
            if (m_pc == LEAD) begin e_rst = 1; m_pend = 0; m_pc = 0; end
            else m_pc++;
        end else if (exc) begin
            if (irq_before_reset) begin e_irq = 1; m_pend = 1; m_pc = 1; end
            else e_rst = 1;
        end
    endtask

    task automatic check(input bit act_v, input bit exp_v, input string what, input string tag);
        n_checks++;
        if (act_v !== exp_v) begin
            n_errors++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act_v, exp_v, $time);
        end
    endtask

    task automatic compare_all();
        check(refresh_done, e_done, "refresh_done", cur_tag);
        check(irq,          e_irq,  "irq",          cur_tag);
        check(reset_req,    e_rst,  "reset_req",    cur_tag);
    endtask

    task automatic cyc(input bit en, input logic [1:0] be, input logic [15:0] d);
        @(negedge clk);
        wr_en = en; wr_be = be; wr_data = d;
        @(posedge clk);
        model_edge();
        #2;
        compare_all();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 2'b00, 16'h0000);
    endtask

    function automatic logic [7:0] pick_byte(input int lane);
        int r;
        r = $urandom_range(0, 9);
        if (r < 4) return (lane == 1) ? 8'hA6 : 8'h02;
        if (r < 8) return (lane == 1) ? 8'hB4 : 8'h80;
        return 8'($urandom);
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd12345));
        model_reset();
        repeat (3) @(posedge clk);
        #2;
        check(refresh_done, 0, "refresh_done in reset", "R1");
        check(irq, 0, "irq in reset", "R1");
        check(reset_req, 0, "reset_req in reset", "R1");
        @(negedge clk); rst = 0;

        cur_tag = "R1";
        cyc(1, 2'b11, 16'hB480);
        check(refresh_done, 0, "no refresh from init", "R1");
        idle(2);

        cur_tag = "R2";
        cyc(1, 2'b11, 16'hA602);
        cyc(1, 2'b11, 16'hB480);
        check(refresh_done, 1, "refresh pulse", "R2");
        idle(1);
        check(refresh_done, 0, "pulse one cycle", "R2");

        cur_tag = "R3";
        cyc(1, 2'b10, 16'hA600);
        check(reset_req, 0, "no exc on half write", "R3");
        cyc(1, 2'b01, 16'h0002);
        cyc(1, 2'b10, 16'hB400);
        cur_tag = "R6";
        check(refresh_done, 0, "mixed B402 no match", "R6");
        check(reset_req, 0, "mixed B402 no exc", "R6");
        cur_tag = "R3";
        cyc(1, 2'b01, 16'h0080);
        check(refresh_done, 1, "split refresh", "R3");

        cur_tag = "R12";
        cyc(1, 2'b00, 16'h1234);
        check(reset_req, 0, "no-lane write ignored", "R12");
        cyc(1, 2'b01, 16'hFF80);
        check(reset_req, 0, "disabled lane kept", "R12");

        cur_tag = "R8";
        cyc(1, 2'b11, 16'hB480);
        check(refresh_done, 0, "second value in idle", "R8");
        check(reset_req, 0, "second value in idle no exc", "R8");

        cur_tag = "R7";
        cyc(1, 2'b11, 16'hA602);
        idle(WIN - 1);
        cyc(1, 2'b11, 16'hB480);
        check(refresh_done, 1, "gap WINDOW accepted", "R7");
        cyc(1, 2'b11, 16'hA602);
        idle(WIN);
        cyc(1, 2'b11, 16'hB480);
        check(refresh_done, 0, "gap WINDOW+1 rejected", "R7");

        cur_tag = "R4";
        irq_before_reset = 0;
        cyc(1, 2'b10, 16'h1200);
        check(reset_req, 1, "bad high byte", "R4");
        cur_tag = "R9";
        check(irq, 0, "no irq in direct mode", "R9");
        cyc(1, 2'b11, 16'hA602);

        cur_tag = "R11";
        cyc(1, 2'b01, 16'h0055);
        cyc(1, 2'b11, 16'hB480);
        check(refresh_done, 0, "tracker idle after exc", "R11");

        cur_tag = "R5";
        irq_before_reset = 1;
        cyc(1, 2'b01, 16'h0033);
        check(irq, 1, "bad low byte irq", "R5");
        cur_tag = "R10";
        check(reset_req, 0, "reset delayed", "R10");
        idle(LEAD - 1);
        check(reset_req, 0, "reset not yet", "R10");
        idle(1);
        check(reset_req, 1, "reset after lead", "R10");
        cyc(1, 2'b11, 16'hB480);

        cur_tag = "R2";
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 49) == 0) irq_before_reset = $urandom_range(0, 1);
            if ($urandom_range(0, 1) == 0) begin
                cyc(0, 2'b00, 16'h0000);
            end else begin
                logic [1:0] be;
                be = 2'($urandom_range(0, 3));
                cyc(1, be, {pick_byte(1), pick_byte(0)});
            end
        end

        finished = 1;
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule